// File: doc/BRIEF.md
# Interrupt Controller Register Block

This block collects up to 32 external interrupt request lines. It keeps three pieces of state for each line: an enable bit, a pending bit and a small priority value. Software reaches this state through a single-cycle word-wide register port. Enable and pending bits each have one word for setting bits and another word for clearing them, so one line can be changed without a read-modify-write. Priority values are packed one per byte, four lines to a 32-bit word, and are written a whole word at a time.

A rising level on a request line makes that line pending. The block compares every line that is both pending and enabled, every cycle. It reports the most urgent one on `irqValid` / `irqId`. A one-cycle acknowledge from the core retires the reported line by clearing its pending bit. Register reads are combinational on the address. Writes and acknowledges take effect at the next rising clock edge, and the reported winner follows the registered state in the same cycle that the state changes.

Top module: `intc_regblock`

## Requirements
- R1: After reset every enable bit, pending bit and priority field is zero, and `irqValid` is low.
- R2: A write to byte address 0x000 sets each enable bit whose data bit is 1 and leaves the rest unchanged (a zero word changes nothing). A read of 0x000 or of 0x080 returns the enable vector, with line n at bit n.
- R3: A write to 0x080 clears each enable bit whose data bit is 1. Zero data bits leave their lines unchanged.
- R4: A write to 0x100 sets each pending bit whose data bit is 1. Zero data bits have no effect. A read of 0x100 or of 0x180 returns the pending vector, with line n at bit n.
- R5: A write to 0x180 clears each pending bit whose data bit is 1. Zero data bits have no effect.
- R6: There are eight priority words at 0x300 + 4*k. Line n uses bits [8*(n%4)+7 : 8*(n%4)+6] of word n/4. The lower six bits of every byte read as zero, and writes to them are discarded.
- R7: A 0-to-1 change on `irqIn[n]` sets pending bit n, whether or not line n is enabled. A line held high does not set its bit again once software has cleared it. A line already high when reset is released counts as rising.
- R8: `irqValid` is high exactly when some line is both pending and enabled. `irqId` then names the line with the smallest priority value, and a tie goes to the lower line number.
- R9: `irqAck` high while `irqValid` is high clears the pending bit of the line shown on `irqId` at that edge. `irqAck` while `irqValid` is low changes nothing.
- R10: In one cycle, a set cause (a rising edge or a set-pending write) beats a clear cause (a clear-pending write or an acknowledge). With no write, no acknowledge and no rising edge, the enable and pending state holds.
- R11: Any other address, including a word address with a nonzero value in bits [1:0], reads as zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busValid | input | 1 | Register access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address of the register word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational on busAddr |
| irqIn | input | 32 | Interrupt request levels, one per line |
| irqAck | input | 1 | Core acknowledge of the reported line |
| irqValid | output | 1 | Some line is pending and enabled |
| irqId | output | 5 | Number of the winning line |

## Verification
Several checks run on every cycle. The reported line must really be pending and enabled. The valid flag must drop when no line qualifies. Each rising request must be pending on the next cycle. An acknowledge with no competing set cause must retire its line. Enable and pending state must hold when nothing acts on them. The assertions cannot see whether the winner is the most urgent line, how priority bytes map onto words, or which data bits each window acts on. The bench scenarios show these, by comparing read-back values and the winner against a model worked out from the requirements, over swept patterns of enables, pending bits and priorities.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_LINES  = 32;
  localparam int LINE_W     = $clog2(NUM_LINES);
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 12;
  localparam int LANES      = 4;                    // priority bytes per word
  localparam int LANE_W     = DATA_W / LANES;
  localparam int LANE_IDX_W = $clog2(LANES);
  localparam int PRIO_BITS  = 2;                    // implemented bits at top of each byte
  localparam int PRIO_WORDS = NUM_LINES / LANES;
  localparam int PWORD_W    = $clog2(PRIO_WORDS);

  typedef enum logic [1:0] {
    RD_NONE,
    RD_ENABLE,
    RD_PENDING,
    RD_PRIORITY
  } rdSel_e;

  typedef struct packed {
    logic               setEn;
    logic               clrEn;
    logic               setPend;
    logic               clrPend;
    logic               prioWr;
    logic [PWORD_W-1:0] prioWord;
    rdSel_e             rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          busValid,
  input  logic          busWrite,
  input  logic [AW-1:0] busAddr,
  output ctrlStrobe_t   strobe
);
  localparam logic [AW-1:0] SET_EN_OFS   = AW'('h000);
  localparam logic [AW-1:0] CLR_EN_OFS   = AW'('h080);
  localparam logic [AW-1:0] SET_PEND_OFS = AW'('h100);
  localparam logic [AW-1:0] CLR_PEND_OFS = AW'('h180);
  localparam logic [AW-1:0] PRIO_OFS     = AW'('h300);
  localparam int            PRIO_LSB     = 2 + PWORD_W;

  logic wrNow;
  logic prioHit;

  assign wrNow   = busValid && busWrite;
  assign prioHit = (busAddr[AW-1:PRIO_LSB] == PRIO_OFS[AW-1:PRIO_LSB]) &&
                   (busAddr[1:0] == 2'b00);

  always_comb begin
    strobe          = '0;
    strobe.rdSel    = RD_NONE;
    strobe.prioWord = busAddr[PRIO_LSB-1:2];
    if (busAddr == SET_EN_OFS) begin
      strobe.setEn = wrNow;
      strobe.rdSel = RD_ENABLE;
    end else if (busAddr == CLR_EN_OFS) begin
      strobe.clrEn = wrNow;
      strobe.rdSel = RD_ENABLE;
    end else if (busAddr == SET_PEND_OFS) begin
      strobe.setPend = wrNow;
      strobe.rdSel   = RD_PENDING;
    end else if (busAddr == CLR_PEND_OFS) begin
      strobe.clrPend = wrNow;
      strobe.rdSel   = RD_PENDING;
    end else if (prioHit) begin
      strobe.prioWr = wrNow;
      strobe.rdSel  = RD_PRIORITY;
    end
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NL = NUM_LINES,
  parameter int DW = DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DW-1:0]     wdata,
  input  logic [NL-1:0]     irqIn,
  input  logic              irqAck,
  output logic [DW-1:0]     rdata,
  output logic              irqValid,
  output logic [LINE_W-1:0] irqId,
  output logic [NL-1:0]     enOut,
  output logic [NL-1:0]     pendOut
);
  logic [NL-1:0]                enQ;
  logic [NL-1:0]                pendQ;
  logic [NL-1:0]                prevQ;
  logic [NL-1:0][PRIO_BITS-1:0] prioQ;

  logic [NL-1:0] riseVec;
  logic [NL-1:0] setEnMask, clrEnMask;
  logic [NL-1:0] setPendMask, clrPendMask, ackMask;
  logic [NL-1:0] candidates;

  assign riseVec     = irqIn & ~prevQ;
  assign setEnMask   = strobe.setEn   ? wdata[NL-1:0] : '0;
  assign clrEnMask   = strobe.clrEn   ? wdata[NL-1:0] : '0;
  assign setPendMask = strobe.setPend ? wdata[NL-1:0] : '0;
  assign clrPendMask = strobe.clrPend ? wdata[NL-1:0] : '0;
  assign ackMask     = (irqAck && irqValid) ? (NL'(1) << irqId) : '0;

  // state registers: set causes are ORed in after clear causes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ   <= '0;
      pendQ <= '0;
      prevQ <= '0;
    end else begin
      enQ   <= (enQ & ~clrEnMask) | setEnMask;
      pendQ <= (pendQ & ~(clrPendMask | ackMask)) | riseVec | setPendMask;
      prevQ <= irqIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prioQ <= '0;
    end else if (strobe.prioWr) begin
      for (int i = 0; i < NL; i++) begin
        if (strobe.prioWord == PWORD_W'(i / LANES))
          prioQ[i] <= wdata[(i % LANES)*LANE_W + LANE_W - 1 -: PRIO_BITS];
      end
    end
  end

  // arbiter: smallest value wins, strict compare keeps lowest index on ties
  assign candidates = enQ & pendQ;

  always_comb begin
    logic                 found;
    logic [LINE_W-1:0]    bestId;
    logic [PRIO_BITS-1:0] bestPrio;
    found    = 1'b0;
    bestId   = '0;
    bestPrio = '1;
    for (int i = 0; i < NL; i++) begin
      if (candidates[i] && (!found || (prioQ[i] < bestPrio))) begin
        found    = 1'b1;
        bestId   = LINE_W'(i);
        bestPrio = prioQ[i];
      end
    end
    irqValid = found;
    irqId    = bestId;
  end

  // read mux
  always_comb begin
    logic [DW-1:0]     prioWord;
    logic [LINE_W-1:0] lineIdx;
    prioWord = '0;
    for (int j = 0; j < LANES; j++) begin
      lineIdx = {strobe.prioWord, LANE_IDX_W'(j)};
      prioWord[j*LANE_W + LANE_W - 1 -: PRIO_BITS] = prioQ[lineIdx];
    end
    case (strobe.rdSel)
      RD_ENABLE:   rdata = DW'(enQ);
      RD_PENDING:  rdata = DW'(pendQ);
      RD_PRIORITY: rdata = prioWord;
      default:     rdata = '0;
    endcase
  end

  assign enOut   = enQ;
  assign pendOut = pendQ;
endmodule

// File: rtl/intc_regblock.sv
module intc_regblock
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic              irqAck,
  output logic              irqValid,
  output logic [LINE_W-1:0] irqId
);
  ctrlStrobe_t           strobe;
  logic [NUM_LINES-1:0]  enState;
  logic [NUM_LINES-1:0]  pendState;

  intc_ctrl #(.AW(ADDR_W)) ctrlInst (
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobe   (strobe)
  );

  intc_datapath #(.NL(NUM_LINES), .DW(DATA_W)) dpInst (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wdata    (busWdata),
    .irqIn    (irqIn),
    .irqAck   (irqAck),
    .rdata    (busRdata),
    .irqValid (irqValid),
    .irqId    (irqId),
    .enOut    (enState),
    .pendOut  (pendState)
  );
endmodule

// File: rtl/intc_checker.sv
module intc_checker
  import intc_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 busValid,
  input logic                 busWrite,
  input logic [NUM_LINES-1:0] irqIn,
  input logic                 irqAck,
  input logic                 irqValid,
  input logic [LINE_W-1:0]    irqId,
  input logic [NUM_LINES-1:0] enState,
  input logic [NUM_LINES-1:0] pendState
);
  logic [NUM_LINES-1:0] seenIn;
  logic [NUM_LINES-1:0] rising;
  logic                 anyWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenIn <= '0;
    else       seenIn <= irqIn;
  end

  assign rising   = irqIn & ~seenIn;
  assign anyWrite = busValid && busWrite;

  AST_WINNER_ARMED: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> (enState[irqId] && pendState[irqId])); // R8

  AST_IDLE_NO_CANDIDATE: assert property (@(posedge clk) disable iff (!rstN)
    !irqValid |-> ((enState & pendState) == '0)); // R8

  AST_RISE_LATCHES: assert property (@(posedge clk) disable iff (!rstN)
    (rising != '0) |=> ((pendState & $past(rising)) == $past(rising))); // R7

  AST_ACK_RETIRES: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && irqValid && !anyWrite && !rising[irqId]) |=> !pendState[$past(irqId)]); // R9

  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!anyWrite && !irqAck && (rising == '0)) |=> ($stable(pendState) && $stable(enState))); // R10
endmodule

bind intc_regblock intc_checker chkInst (
  .clk       (clk),
  .rstN      (rstN),
  .busValid  (busValid),
  .busWrite  (busWrite),
  .irqIn     (irqIn),
  .irqAck    (irqAck),
  .irqValid  (irqValid),
  .irqId     (irqId),
  .enState   (enState),
  .pendState (pendState)
);

// File: tb/intc_regblock_test.sv
module intc_regblock_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        busValid, busWrite;
  logic [11:0] busAddr;
  logic [31:0] busWdata, busRdata;
  logic [31:0] irqIn;
  logic        irqAck, irqValid;
  logic [4:0]  irqId;

  int checks = 0;
  int errors = 0;

  logic [31:0] mEn, mPend;
  logic [1:0]  mPrio [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_regblock uut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqIn(irqIn), .irqAck(irqAck), .irqValid(irqValid), .irqId(irqId)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0; busWdata = '0;
  endtask

  task automatic busRd(input logic [11:0] a, output logic [31:0] d);
    busAddr = a; busValid = 1'b1; busWrite = 1'b0;
    #1 d = busRdata;
    busValid = 1'b0;
  endtask

  task automatic expectRd(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    busRd(a, d);
    check(tag, d, exp);
  endtask

  task automatic setPrio(input int k, input logic [31:0] d);
    busWr(12'(12'h300 + 4*k), d);
    for (int j = 0; j < 4; j++) mPrio[4*k + j] = d[j*8 + 6 +: 2];
  endtask

  function automatic logic [31:0] expWinner();
    logic       v = 1'b0;
    logic [4:0] id = '0;
    logic [1:0] bp = 2'd3;
    for (int i = 0; i < 32; i++) begin
      if (mEn[i] && mPend[i] && (!v || mPrio[i] < bp)) begin
        v = 1'b1; id = 5'(i); bp = mPrio[i];
      end
    end
    return v ? {26'd0, 1'b1, id} : 32'd0;
  endfunction

  task automatic checkWinner(input string tag);
    logic [31:0] act;
    act = irqValid ? {26'd0, 1'b1, irqId} : 32'd0;
    check(tag, act, expWinner());
  endtask

  task automatic ackOnce();
    @(negedge clk); irqAck = 1'b1;
    @(negedge clk); irqAck = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed, a, b, c, d;
    rstN = 1'b0; busValid = 1'b0; busWrite = 1'b0; busAddr = '0; busWdata = '0;
    irqIn = '0; irqAck = 1'b0;
    mEn = '0; mPend = '0;
    for (int i = 0; i < 32; i++) mPrio[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    expectRd("R1 enable", 12'h000, 32'h0);
    expectRd("R1 pending", 12'h100, 32'h0);
    for (int k = 0; k < 8; k++) expectRd("R1 priority", 12'(12'h300 + 4*k), 32'h0);
    check("R1 irqValid", {31'd0, irqValid}, 32'd0);

    // R2 set-enable window
    a = 32'hA5A5_0F0F; b = 32'h0000_F0F0;
    busWr(12'h000, a); expectRd("R2 set a", 12'h000, a);
    busWr(12'h000, 32'h0); expectRd("R2 zero ignored", 12'h000, a);
    busWr(12'h000, b); expectRd("R2 set b", 12'h000, a | b);
    expectRd("R2 alias read", 12'h080, a | b);

    // R3 clear-enable window
    c = 32'h0F0F_00F0;
    busWr(12'h080, c); expectRd("R3 clear", 12'h000, (a | b) & ~c);
    busWr(12'h080, 32'h0); expectRd("R3 zero ignored", 12'h080, (a | b) & ~c);
    busWr(12'h080, 32'hFFFF_FFFF); expectRd("R3 clear all", 12'h000, 32'h0);

    // R4 / R5 walking set and clear of pending bits
    for (int i = 0; i < 32; i++) begin
      busWr(12'h100, 32'd1 << i);
      expectRd("R4 walk set", 12'h100, 32'((64'd1 << (i + 1)) - 1));
    end
    expectRd("R4 alias read", 12'h180, 32'hFFFF_FFFF);
    busWr(12'h100, 32'h0); expectRd("R4 zero ignored", 12'h100, 32'hFFFF_FFFF);
    busWr(12'h180, 32'h0); expectRd("R5 zero ignored", 12'h100, 32'hFFFF_FFFF);
    for (int i = 0; i < 32; i++) begin
      busWr(12'h180, 32'd1 << i);
      expectRd("R5 walk clear", 12'h180, ~32'((64'd1 << (i + 1)) - 1));
    end

    // R6 priority words
    for (int k = 0; k < 8; k++) begin
      d = 32'h9E37_79B9 * 32'(k + 1);
      setPrio(k, d);
      expectRd("R6 readback", 12'(12'h300 + 4*k), d & 32'hC0C0_C0C0);
    end
    for (int k = 0; k < 8; k++) begin
      d = 32'h9E37_79B9 * 32'(k + 1);
      expectRd("R6 no aliasing", 12'(12'h300 + 4*k), d & 32'hC0C0_C0C0);
    end

    // R7 rising edges, line disabled
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); irqIn = 32'd1 << i;
      @(negedge clk);
      expectRd("R7 edge sets", 12'h100, 32'd1 << i);
      check("R7 disabled not reported", {31'd0, irqValid}, 32'd0);
      busWr(12'h180, 32'd1 << i);
      @(negedge clk);
      expectRd("R7 held level no reset", 12'h100, 32'h0);
      irqIn = '0;
    end

    // R8 arbitration sweep
    seed = 32'h1234_5678;
    for (int p = 0; p < 48; p++) begin
      seed = seed * 32'd1103515245 + 32'd12345; a = seed;
      seed = seed * 32'd1103515245 + 32'd12345; b = seed | 32'h0100_0010;
      seed = seed * 32'd1103515245 + 32'd12345;
      setPrio(p % 8, seed);
      busWr(12'h080, 32'hFFFF_FFFF); busWr(12'h000, b); mEn = b;
      busWr(12'h180, 32'hFFFF_FFFF); busWr(12'h100, a); mPend = a;
      checkWinner("R8 sweep");
    end
    for (int k = 0; k < 8; k++) setPrio(k, 32'h0);
    busWr(12'h000, 32'hFFFF_FFFF); mEn = 32'hFFFF_FFFF;
    busWr(12'h180, 32'hFFFF_FFFF); busWr(12'h100, 32'h8040_0200); mPend = 32'h8040_0200;
    checkWinner("R8 tie lowest index");
    busWr(12'h180, 32'hFFFF_FFFF); mPend = '0;
    checkWinner("R8 none pending");

    // R9 drain in priority order
    setPrio(0, 32'hC0_80_40_00); setPrio(3, 32'h00_40_80_C0); setPrio(7, 32'h40_40_00_80);
    busWr(12'h100, 32'hFFFF_FFFF); mPend = 32'hFFFF_FFFF;
    for (int n = 0; n < 33; n++) begin
      logic [31:0] w;
      w = expWinner();
      checkWinner("R9 drain order");
      if (!w[5]) break;
      ackOnce();
      mPend[w[4:0]] = 1'b0;
    end
    check("R9 drained", {31'd0, irqValid}, 32'd0);

    // R10 set beats clear in the same cycle
    for (int k = 0; k < 8; k++) setPrio(k, 32'h0);
    busWr(12'h100, 32'h8); mPend = 32'h8;
    checkWinner("R10 setup");
    @(negedge clk); irqAck = 1'b1; irqIn = 32'h8;
    @(negedge clk); irqAck = 1'b0;
    expectRd("R10 rise beats ack", 12'h100, 32'h8);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = 12'h180; busWdata = 32'h28; irqIn = 32'h28;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
    expectRd("R10 rise beats clear write", 12'h100, 32'h20);
    repeat (5) @(negedge clk);
    expectRd("R10 quiet pending", 12'h100, 32'h20);
    expectRd("R10 quiet enable", 12'h000, 32'hFFFF_FFFF);
    irqIn = '0;

    // R9 ack with nothing reported
    busWr(12'h080, 32'hFFFF_FFFF); mEn = '0;
    check("R9 idle before ack", {31'd0, irqValid}, 32'd0);
    ackOnce();
    expectRd("R9 idle ack no effect", 12'h100, 32'h20);

    // R11 unmapped and misaligned addresses
    busWr(12'h040, 32'hFFFF_FFFF);
    busWr(12'h001, 32'hFFFF_FFFF);
    busWr(12'h302, 32'hFFFF_FFFF);
    busWr(12'h320, 32'hFFFF_FFFF);
    expectRd("R11 unmapped read", 12'h040, 32'h0);
    expectRd("R11 misaligned read", 12'h302, 32'h0);
    expectRd("R11 past priority read", 12'h320, 32'h0);
    expectRd("R11 enable untouched", 12'h000, 32'h0);
    expectRd("R11 pending untouched", 12'h100, 32'h20);
    expectRd("R11 priority untouched", 12'h300, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule